// File: doc/BRIEF.md
# Interrupt Port Level Driver

This block is a single write-only register in a 64-byte memory-mapped window that sets the level held on one of several interrupt output lines. Each line is intended to feed the level-sensitive external interrupt input of one processor. Line k goes to processor k. One two-byte store names the target line and the level to drive on it. Firmware can therefore raise, lower or reassign the level of any line with one write, and no line needs its own enable bit.

The window is decoded on the low six bits of the byte address, so the register also appears at every aliased copy of the window higher in the address space. Byte order is big-endian. The lower-addressed byte of the halfword is the line number and the higher-addressed byte is the level. A store that carries only the line-number byte drives level 0 on the chosen line. Each line keeps its level until a later store names it again. A store that names a line that does not exist changes nothing and sets a sticky error flag. The flag clears only on reset.

Top module: `irq_line_driver`

## Requirements
- R1: After reset, every output line carries level 0 and `bad_line` is 0.
- R2: A store takes effect only when `wr_en` is 1 and `addr[5:0]` equals 0x08, whatever the higher address bits are. A store to any other offset leaves all lines and `bad_line` unchanged.
- R3: A store with `byte_en` = 2'b11 sets line `wdata[15:8]` to level `wdata[7:0]` (truncated to LEVEL_W bits). The new level is visible on the clock edge that samples the store. For example, data 0x0102 drives level 2 on line 1.
- R4: A store with `byte_en` = 2'b10 (line byte only) sets the chosen line to level 0.
- R5: A line holds its level across stores that name another line. A store with `byte_en[1]` = 0 is ignored.
- R6: A store whose line number is NUM_LINES or more leaves every line unchanged and sets `bad_line`. `bad_line` stays 1 until reset.
- R7: `rdata` reads as zero at all times, because the register has no read function.
- R8: Line k is driven on `irq_level[k*LEVEL_W +: LEVEL_W]`, from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for this window, one cycle per store |
| addr | input | ADDR_W | Byte address of the store. Only bits [5:0] are decoded |
| byte_en | input | 2 | Lane enables: [1] = line byte (offset 0x08), [0] = level byte (offset 0x09) |
| wdata | input | 16 | Store data: [15:8] = line number, [7:0] = level |
| rdata | output | 16 | Read data, always zero |
| irq_level | output | NUM_LINES*LEVEL_W | Held levels of all interrupt lines, packed by line number |
| bad_line | output | 1 | Sticky flag set by a store to a nonexistent line |

## Verification
The bench builds the block with NUM_LINES = 4, LEVEL_W = 8 and ADDR_W = 16. With only four lines, every line can be checked against a model after every store. Every line number from 0 to 7, and also 255, fits in a short sweep. This puts the in-range/out-of-range boundary at 3 and 4, so both sides of it are exercised. The small address width lets the bench sweep all 64 window offsets and several aliased upper-address copies. Each line is also driven with one-byte stores and with stores that omit the line byte.

// File: rtl/irq_line_driver.sv
module irq_line_driver #(
  parameter int NUM_LINES = 8,
  parameter int LEVEL_W   = 8,
  parameter int ADDR_W    = 16,
  parameter logic [5:0] REG_OFS = 6'h08
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [1:0]                    byte_en,
  input  logic [15:0]                   wdata,
  output logic [15:0]                   rdata,
  output logic [NUM_LINES*LEVEL_W-1:0]  irq_level,
  output logic                          bad_line
);

  localparam int WIN_BITS = 6;
  localparam int SEL_W    = 8;

  logic               hit;
  logic [SEL_W-1:0]   sel;
  logic               in_range;
  logic [LEVEL_W-1:0] new_lvl;

  assign hit      = wr_en && (addr[WIN_BITS-1:0] == REG_OFS) && byte_en[1];
  assign sel      = wdata[15:8];
  assign in_range = (32'(sel) < NUM_LINES);
  assign new_lvl  = byte_en[0] ? wdata[LEVEL_W-1:0] : '0;
  assign rdata    = '0;

  always_ff @(posedge clk) begin
    if (!rst_n)                bad_line <= 1'b0;
    else if (hit && !in_range) bad_line <= 1'b1;
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [LEVEL_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
      if (!rst_n)                           lvl_q <= '0;
      else if (hit && sel == SEL_W'(k))     lvl_q <= new_lvl;
    end

    assign irq_level[k*LEVEL_W +: LEVEL_W] = lvl_q;

    a_r3_full_store: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel == SEL_W'(k) && byte_en[0])
        |=> irq_level[k*LEVEL_W +: LEVEL_W] == $past(wdata[LEVEL_W-1:0]));

    a_r4_line_only: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel == SEL_W'(k) && !byte_en[0])
        |=> irq_level[k*LEVEL_W +: LEVEL_W] == '0);

    a_r5_hold_other: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && byte_en[1] && addr[WIN_BITS-1:0] == REG_OFS) || wdata[15:8] != SEL_W'(k))
        |=> $stable(irq_level[k*LEVEL_W +: LEVEL_W]));
  end

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_line |=> bad_line);

  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_en[1] && addr[WIN_BITS-1:0] == REG_OFS && 32'(wdata[15:8]) >= NUM_LINES)
      |=> bad_line && $stable(irq_level));

  a_r2_off_window: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[WIN_BITS-1:0] != REG_OFS) |=> $stable(irq_level) && (bad_line == $past(bad_line)));

endmodule

// File: tb/irq_line_driver_test.sv
module irq_line_driver_test;
  localparam int NL = 4;
  localparam int LW = 8;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [1:0] byte_en = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [NL*LW-1:0] irq_level;
  logic bad_line;

  int checks = 0, errors = 0;
  logic [LW-1:0] exp_lvl [NL];
  logic exp_err;
  bit done = 0;

  always #2 clk = ~clk;

  irq_line_driver #(.NUM_LINES(NL), .LEVEL_W(LW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .byte_en(byte_en),
    .wdata(wdata), .rdata(rdata), .irq_level(irq_level), .bad_line(bad_line));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NL; k++)
      chk({req, " R8 line level"}, 32'(irq_level[k*LW +: LW]), 32'(exp_lvl[k]));
    chk({req, " R6 bad_line"}, 32'(bad_line), 32'(exp_err));
    chk("R7 rdata", 32'(rdata), 32'h0);
  endtask

  task automatic store(logic [AW-1:0] a, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; byte_en = be; wdata = d;
    @(negedge clk);
    wr_en = 0; byte_en = '0;
  endtask

  task automatic model(logic [AW-1:0] a, logic [1:0] be, logic [15:0] d);
    if (a[5:0] == 6'h08 && be[1]) begin
      if (32'(d[15:8]) < NL) exp_lvl[d[15:8]] = be[0] ? d[LW-1:0] : '0;
      else exp_err = 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    for (int k = 0; k < NL; k++) exp_lvl[k] = '0;
    exp_err = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lv;
    do_reset();
    check_all("R1 reset");

    // R3 example: 0x0102 drives level 2 on line 1
    store(16'h0008, 2'b11, 16'h0102); model(16'h0008, 2'b11, 16'h0102);
    chk("R3 example line1", 32'(irq_level[1*LW +: LW]), 32'h2);
    check_all("R3 example");

    // R3/R5/R6 sweep of line numbers and levels
    for (int ln = 0; ln < 8; ln++) begin
      for (int v = 0; v < 4; v++) begin
        lv = (v == 0) ? 8'h00 : (v == 1) ? 8'h5A : (v == 2) ? 8'hFF : 8'(ln*17 + 3);
        store(16'h0008, 2'b11, {8'(ln), lv}); model(16'h0008, 2'b11, {8'(ln), lv});
        check_all(ln < NL ? "R3 R5 full store" : "R6 out of range");
      end
    end
    store(16'h0008, 2'b11, 16'hFF33); model(16'h0008, 2'b11, 16'hFF33);
    check_all("R6 line 255");

    do_reset();
    check_all("R1 reset clears sticky");

    // R4 one-byte stores after setting nonzero levels
    for (int ln = 0; ln < NL; ln++) begin
      store(16'h0008, 2'b11, {8'(ln), 8'(8'hA0 + ln)}); model(16'h0008, 2'b11, {8'(ln), 8'(8'hA0 + ln)});
    end
    check_all("R3 setup");
    for (int ln = 0; ln < NL; ln++) begin
      store(16'h0008, 2'b10, {8'(ln), 8'hEE}); model(16'h0008, 2'b10, {8'(ln), 8'hEE});
      check_all("R4 line byte only");
      store(16'h0008, 2'b11, {8'(ln), 8'(8'hC0 + ln)}); model(16'h0008, 2'b11, {8'(ln), 8'(8'hC0 + ln)});
    end

    // R5: level byte only, or no line byte, is ignored
    store(16'h0008, 2'b01, 16'h0011); model(16'h0008, 2'b01, 16'h0011);
    check_all("R5 be=01 ignored");
    store(16'h0008, 2'b00, 16'h0122); model(16'h0008, 2'b00, 16'h0122);
    check_all("R5 be=00 ignored");
    @(negedge clk); addr = 16'h0008; byte_en = 2'b11; wdata = 16'h0233;
    @(negedge clk); byte_en = '0;
    check_all("R2 no strobe ignored");

    // R2: every other offset in the window is ignored
    for (int o = 0; o < 64; o++) begin
      if (o != 8) begin
        store(16'(o), 2'b11, 16'h0077); model(16'(o), 2'b11, 16'h0077);
        check_all("R2 other offset");
      end
    end
    // R2: aliases in upper address bits
    for (int u = 0; u < 4; u++) begin
      store(16'(u * 16'h1040 + 16'h0008), 2'b11, {8'(u), 8'(8'h10 + u)});
      model(16'(u * 16'h1040 + 16'h0008), 2'b11, {8'(u), 8'(8'h10 + u)});
      check_all("R2 alias");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule